// File: doc/BRIEF.md
# Multi-Mode Operand Fetch and Add Unit

This block carries out one two-operand add. The second operand can come from ten different sources: a register, the constant field, or a word in memory. For a memory operand, the address is formed from the base register, the index register and the constant in one of several ways. The block holds a 16 x 32-bit register file. The destination register receives its old value plus the operand, after the operand has been zero-extended from the selected size.

A start pulse supplies the mode, the size, three register numbers and the constant. Memory operands are fetched from an external synchronous memory. The block raises a request with an address and waits for a one-cycle valid pulse that carries the word. One mode follows a pointer, so it reads memory twice in a row. Two modes move the base register by the operand size, one after the read and one before it. A one-cycle done pulse presents the sum that was written.

Top module: `opfetch_unit`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are low and every register holds zero.
- R2: Mode code 0 (register) adds register idx_i to the destination and makes no memory read.
- R3: Mode code 1 (constant) adds const_i to the destination and makes no memory read. Codes 10 to 15 behave the same way.
- R4: Memory modes make exactly one read, at these addresses: code 2 reads const_i + base; code 3 reads base; code 4 reads base + index; code 5 reads const_i.
- R5: Mode code 6 makes two reads in order. The first is at base, and the second is at the word returned by the first. The second word is the operand.
- R6: Mode code 7 reads at the current base value, and afterwards the base register is increased by d.
- R7: Mode code 8 decreases the base register by d and reads at the decreased value.
- R8: Mode code 9 reads at const_i + base + index * d.
- R9: size_i selects the operand width: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. d is then 1, 2 or 4. The operand is the low bits of the word, zero-extended before the add.
- R10: mem_req_o stays high with mem_addr_o stable until a cycle with mem_valid_i high. mem_rdata_i is taken in that cycle.
- R11: busy_o is high from an accepted start until done. done_o is a one-cycle pulse with wb_data_o equal to the value written. start_i is ignored while busy.
- R12: When modes 7 or 8 name the same register as base and destination, the register ends holding the sum. The sum uses the register's value from before the base update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| mode_i | input | 4 | Operand source mode code |
| size_i | input | 2 | Operand size code |
| dst_i | input | 4 | Destination register number |
| base_i | input | 4 | Base register number |
| idx_i | input | 4 | Index / second register number |
| const_i | input | 32 | Constant field |
| busy_o | output | 1 | Instruction in flight |
| done_o | output | 1 | One-cycle completion pulse |
| wb_data_o | output | 32 | Sum written to the destination |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_valid_i | input | 1 | Read data valid pulse |
| mem_rdata_i | input | 32 | Read data word |

## Verification
The assertions assume that mem_valid_i arrives only while a request is up, and that it lasts a single cycle per request. The bench memory model meets both conditions: it answers only a standing request, lowers valid in the following cycle, and sometimes waits several cycles first so that the request must hold. The checks on read counts per mode also assume that each start happens in an idle cycle. The bench meets that by waiting for done before each new start, except for one stray start that is issued on purpose mid-fetch.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

  typedef enum logic [3:0] {
    M_REG   = 4'd0,
    M_IMM   = 4'd1,
    M_DISP  = 4'd2,
    M_RIND  = 4'd3,
    M_INDEX = 4'd4,
    M_ABS   = 4'd5,
    M_MIND  = 4'd6,
    M_AINC  = 4'd7,
    M_ADEC  = 4'd8,
    M_SCALE = 4'd9
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_WB   = 2'd3
  } state_e;

  function automatic logic is_mem_mode(logic [3:0] m);
    return (m >= 4'd2) && (m <= 4'd9);
  endfunction

  function automatic logic is_auto_mode(logic [3:0] m);
    return (m == 4'd7) || (m == 4'd8);
  endfunction

  // log2 of the operand size in bytes
  function automatic logic [1:0] size_shift(logic [1:0] s);
    case (s)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/opfetch_regfile.sv
module opfetch_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] ra_idx_i,
  input  logic [IW-1:0] rb_idx_i,
  input  logic [IW-1:0] rc_idx_i,
  output logic [DW-1:0] ra_data_o,
  output logic [DW-1:0] rb_data_o,
  output logic [DW-1:0] rc_data_o,
  input  logic          wa_en_i,
  input  logic [IW-1:0] wa_idx_i,
  input  logic [DW-1:0] wa_data_i,
  input  logic          wb_en_i,
  input  logic [IW-1:0] wb_idx_i,
  input  logic [DW-1:0] wb_data_i
);

  logic [DW-1:0]   regs_q [NREG];
  logic [NREG-1:0] hit_a, hit_b;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hit_a[g] = wa_en_i && (wa_idx_i == IW'(g));
    assign hit_b[g] = wb_en_i && (wb_idx_i == IW'(g));
  end

  // port a (sum) wins over port b (base side effect)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (hit_a[i])      regs_q[i] <= wa_data_i;
        else if (hit_b[i]) regs_q[i] <= wb_data_i;
      end
    end
  end

  assign ra_data_o = regs_q[ra_idx_i];
  assign rb_data_o = regs_q[rb_idx_i];
  assign rc_data_o = regs_q[rc_idx_i];

endmodule

// File: rtl/opfetch_agu.sv
module opfetch_agu
  import opfetch_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] base_v_i,
  input  logic [DW-1:0] idx_v_i,
  input  logic [DW-1:0] cst_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] base_nxt_o
);

  logic [1:0]    sh;
  logic [DW-1:0] step, scaled;

  assign sh     = size_shift(size_i);
  assign step   = DW'(1) << sh;
  assign scaled = idx_v_i << sh;

  always_comb begin
    case (mode_i)
      M_DISP:  addr_o = cst_i + base_v_i;
      M_INDEX: addr_o = base_v_i + idx_v_i;
      M_ABS:   addr_o = cst_i;
      M_ADEC:  addr_o = base_v_i - step;
      M_SCALE: addr_o = cst_i + base_v_i + scaled;
      default: addr_o = base_v_i;
    endcase
  end

  always_comb begin
    case (mode_i)
      M_AINC:  base_nxt_o = base_v_i + step;
      M_ADEC:  base_nxt_o = base_v_i - step;
      default: base_nxt_o = base_v_i;
    endcase
  end

endmodule

// File: rtl/opfetch_ctrl.sv
module opfetch_ctrl
  import opfetch_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [IW-1:0] dst_i,
  input  logic [IW-1:0] base_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] cst_i,
  output logic [3:0]    mode_q_o,
  output logic [1:0]    size_q_o,
  output logic [IW-1:0] dst_q_o,
  output logic [IW-1:0] base_q_o,
  output logic [IW-1:0] idx_q_o,
  output logic [DW-1:0] cst_q_o,
  input  logic [DW-1:0] dst_v_i,
  input  logic [DW-1:0] idx_v_i,
  input  logic [DW-1:0] agu_addr_i,
  input  logic [DW-1:0] base_nxt_i,
  output logic          wa_en_o,
  output logic [DW-1:0] wa_data_o,
  output logic          wb_en_o,
  output logic [DW-1:0] wb_data_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] res_o
);

  state_e        st_q;
  logic [3:0]    mode_q;
  logic [1:0]    size_q;
  logic [IW-1:0] dst_q, base_q, idx_q;
  logic [DW-1:0] cst_q, data_q, res_q;
  logic          done_q;
  logic [DW-1:0] op_raw, op_ext, sum;

  always_comb begin
    case (mode_q)
      M_REG:   op_raw = idx_v_i;
      default: op_raw = is_mem_mode(mode_q) ? data_q : cst_q;
    endcase
  end

  always_comb begin
    case (size_q)
      2'd0:    op_ext = DW'(op_raw[7:0]);
      2'd1:    op_ext = DW'(op_raw[15:0]);
      default: op_ext = op_raw;
    endcase
  end

  assign sum = dst_v_i + op_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      size_q <= '0;
      dst_q  <= '0;
      base_q <= '0;
      idx_q  <= '0;
      cst_q  <= '0;
      data_q <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          mode_q <= mode_i;
          size_q <= size_i;
          dst_q  <= dst_i;
          base_q <= base_i;
          idx_q  <= idx_i;
          cst_q  <= cst_i;
          st_q   <= is_mem_mode(mode_i) ? ST_RD1 : ST_WB;
        end
        ST_RD1: if (mem_valid_i) begin
          data_q <= mem_rdata_i;
          st_q   <= (mode_q == M_MIND) ? ST_RD2 : ST_WB;
        end
        ST_RD2: if (mem_valid_i) begin
          data_q <= mem_rdata_i;
          st_q   <= ST_WB;
        end
        default: begin
          res_q  <= sum;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
      endcase
    end
  end

  assign mem_req_o  = (st_q == ST_RD1) || (st_q == ST_RD2);
  assign mem_addr_o = (st_q == ST_RD2) ? data_q :
                      (st_q == ST_RD1) ? agu_addr_i : '0;

  assign wa_en_o   = (st_q == ST_WB);
  assign wa_data_o = sum;
  assign wb_en_o   = (st_q == ST_WB) && is_auto_mode(mode_q);
  assign wb_data_o = base_nxt_i;

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign res_o  = res_q;

  assign mode_q_o = mode_q;
  assign size_q_o = size_q;
  assign dst_q_o  = dst_q;
  assign base_q_o = base_q;
  assign idx_q_o  = idx_q;
  assign cst_q_o  = cst_q;

endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [IW-1:0] dst_i,
  input  logic [IW-1:0] base_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] const_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] wb_data_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i
);

  logic [3:0]    mode_q;
  logic [1:0]    size_q;
  logic [IW-1:0] dst_q, base_q, idx_q;
  logic [DW-1:0] cst_q;
  logic [DW-1:0] dst_v, base_v, idx_v;
  logic [DW-1:0] agu_addr, base_nxt;
  logic          wa_en, wb_en;
  logic [DW-1:0] wa_data, wb_data;

  opfetch_ctrl #(.DW(DW), .IW(IW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .size_i     (size_i),
    .dst_i      (dst_i),
    .base_i     (base_i),
    .idx_i      (idx_i),
    .cst_i      (const_i),
    .mode_q_o   (mode_q),
    .size_q_o   (size_q),
    .dst_q_o    (dst_q),
    .base_q_o   (base_q),
    .idx_q_o    (idx_q),
    .cst_q_o    (cst_q),
    .dst_v_i    (dst_v),
    .idx_v_i    (idx_v),
    .agu_addr_i (agu_addr),
    .base_nxt_i (base_nxt),
    .wa_en_o    (wa_en),
    .wa_data_o  (wa_data),
    .wb_en_o    (wb_en),
    .wb_data_o  (wb_data),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_valid_i(mem_valid_i),
    .mem_rdata_i(mem_rdata_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .res_o      (wb_data_o)
  );

  opfetch_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_idx_i (dst_q),
    .rb_idx_i (base_q),
    .rc_idx_i (idx_q),
    .ra_data_o(dst_v),
    .rb_data_o(base_v),
    .rc_data_o(idx_v),
    .wa_en_i  (wa_en),
    .wa_idx_i (dst_q),
    .wa_data_i(wa_data),
    .wb_en_i  (wb_en),
    .wb_idx_i (base_q),
    .wb_data_i(wb_data)
  );

  opfetch_agu #(.DW(DW)) u_agu (
    .mode_i    (mode_q),
    .size_i    (size_q),
    .base_v_i  (base_v),
    .idx_v_i   (idx_v),
    .cst_i     (cst_q),
    .addr_o    (agu_addr),
    .base_nxt_o(base_nxt)
  );

endmodule

// File: rtl/opfetch_chk.sv
module opfetch_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_valid_i
);

  logic [3:0] mode_t;
  logic [1:0] rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_t <= '0;
      rd_cnt <= '0;
    end else if (start_i && !busy_o) begin
      mode_t <= mode_i;
      rd_cnt <= '0;
    end else if (mem_req_o && mem_valid_i && rd_cnt != 2'd3) begin
      rd_cnt <= rd_cnt + 2'd1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)); // R10
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_REG_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && mode_t == 4'd0 |-> !mem_req_o); // R2
  AST_IMM_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (mode_t == 4'd1 || mode_t >= 4'd10) |-> !mem_req_o); // R3
  AST_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode_t >= 4'd2 && mode_t <= 4'd9 && mode_t != 4'd6 |-> rd_cnt == 2'd1); // R4
  AST_CHAIN_TWO_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode_t == 4'd6 |-> rd_cnt == 2'd2); // R5

endmodule

bind opfetch_unit opfetch_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_valid_i(mem_valid_i)
);

// File: tb/sim_opfetch_unit.sv
module sim_opfetch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [3:0]  dst = '0, base = '0, idx = '0;
  logic [31:0] cst = '0;
  logic        busy, done, mem_req;
  logic [31:0] wb_data, mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_err = 0, n_done = 0, lat = 0, wait_cnt = 0;
  logic [31:0] regs [16];
  logic [31:0] aq[$], wq[$];
  string       atag[$], wtag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  opfetch_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .size_i(size),
    .dst_i(dst), .base_i(base), .idx_i(idx), .const_i(cst),
    .busy_o(busy), .done_o(done), .wb_data_o(wb_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0F0F_1234;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: compares each request address against the expected queue
  initial begin
    forever begin
      @(negedge clk);
      if (mem_valid) mem_valid = 1'b0;
      else if (mem_req) begin
        if (wait_cnt < lat) wait_cnt++;
        else begin
          wait_cnt = 0;
          if (aq.size() == 0) check("R4 unexpected read", mem_addr, 32'hFFFF_FFFF);
          else check(atag.pop_front(), mem_addr, aq.pop_front());
          mem_rdata = mem_word(mem_addr);
          mem_valid = 1'b1;
        end
      end
    end
  end

  // result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        n_done++;
        if (wq.size() == 0) check("R11 unexpected done", wb_data, 32'hFFFF_FFFF);
        else check(wtag.pop_front(), wb_data, wq.pop_front());
      end
    end
  end

  task automatic run(int m, int sz, int rd, int rb, int rx, logic [31:0] k,
                     string tag, bit poke = 1'b0);
    logic [31:0] d, b, x, a, op, ext, sum, nb;
    int tgt;
    d  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    b  = regs[rb];
    x  = regs[rx];
    nb = b;
    a  = '0;
    op = '0;
    case (m)
      0: op = x;
      2: a = k + b;
      3: a = b;
      4: a = b + x;
      5: a = k;
      6: begin aq.push_back(b); atag.push_back({tag, " first read"}); a = mem_word(b); end
      7: begin a = b; nb = b + d; end
      8: begin a = b - d; nb = a; end
      9: a = k + b + x * d;
      default: op = k;
    endcase
    if (m >= 2 && m <= 9) begin
      aq.push_back(a);
      atag.push_back({tag, " address"});
      op = mem_word(a);
    end
    ext = (sz == 0) ? {24'd0, op[7:0]} : (sz == 1) ? {16'd0, op[15:0]} : op;
    sum = regs[rd] + ext;
    regs[rb] = nb;
    regs[rd] = sum;
    wq.push_back(sum);
    wtag.push_back({tag, " sum"});
    tgt = n_done + 1;
    @(negedge clk);
    mode = 4'(m); size = 2'(sz); dst = 4'(rd); base = 4'(rb); idx = 4'(rx); cst = k;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // stray start while busy: must be ignored (R11)
      mode = 4'd1; dst = 4'd15; cst = 32'h77; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (n_done < tgt) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 busy after reset", 32'(busy), 32'd0);
    check("R1 done after reset", 32'(done), 32'd0);
    check("R1 req after reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // register loads through constant mode; first one also shows reset zero (R1)
    run(1, 2, 1, 0, 0, 32'd150,    "R1 R3 load r1");
    run(1, 2, 2, 0, 0, 32'd8,      "R3 load r2");
    run(1, 2, 3, 0, 0, 32'h1000,   "R3 load r3");
    run(1, 2, 4, 0, 0, 32'h20,     "R3 load r4");
    run(1, 2, 5, 0, 0, 32'h400,    "R3 load r5");
    run(1, 2, 6, 0, 0, 32'd5,      "R3 load r6");
    run(12, 2, 6, 0, 0, 32'd3,     "R3 reserved code");
    run(0, 2, 7, 0, 1, 32'hDEAD,   "R2 register add");
    run(0, 0, 7, 0, 3, 32'd0,      "R2 R9 register byte");
    run(2, 2, 8, 1, 0, 32'd100,    "R4 displacement");
    run(3, 1, 8, 3, 0, 32'd0,      "R4 R9 reg indirect half");
    run(3, 0, 9, 3, 0, 32'd0,      "R9 reg indirect byte");
    run(3, 3, 9, 3, 0, 32'd0,      "R9 reg indirect word code3");
    run(4, 0, 9, 3, 4, 32'd0,      "R4 indexed");
    run(5, 2, 9, 0, 0, 32'h3344,   "R4 absolute");
    run(6, 2, 10, 5, 0, 32'd0,     "R5 memory indirect");
    run(6, 0, 10, 2, 0, 32'd0,     "R5 memory indirect byte");
    run(7, 2, 11, 3, 0, 32'd0,     "R6 auto inc word");
    run(7, 0, 11, 3, 0, 32'd0,     "R6 auto inc byte");
    run(0, 2, 12, 0, 3, 32'd0,     "R6 base readback");
    run(8, 1, 11, 5, 0, 32'd0,     "R7 auto dec half");
    run(8, 0, 11, 5, 0, 32'd0,     "R7 auto dec byte");
    run(0, 2, 12, 0, 5, 32'd0,     "R7 base readback");
    run(9, 2, 13, 1, 6, 32'd100,   "R8 scaled word");
    run(9, 1, 13, 1, 6, 32'd100,   "R8 scaled half");
    run(9, 0, 13, 1, 6, 32'd7,     "R8 scaled byte");
    run(7, 2, 4, 4, 0, 32'd0,      "R12 auto inc same reg");
    run(8, 0, 4, 4, 0, 32'd0,      "R12 auto dec same reg");
    run(0, 2, 12, 0, 4, 32'd0,     "R12 readback");
    lat = 3;
    run(2, 2, 14, 1, 0, 32'd40,    "R10 slow memory");
    run(6, 1, 14, 3, 0, 32'd0,     "R10 slow chained reads");
    lat = 1;
    run(5, 2, 14, 0, 0, 32'h500,   "R11 stray start", 1'b1);
    run(0, 2, 14, 0, 15, 32'd0,    "R11 r15 untouched");
    lat = 0;
    repeat (5) @(negedge clk);
    check("R11 queue drained", 32'(wq.size() + aq.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule